// File: doc/BRIEF.md
# Directory Coherence Controller

This block is the home-side directory for a small group of processor caches. For every memory block it holds a coherence state and a presence bitmap, with one bit per cache. Caches send read misses, write misses, upgrades (a write to a block they hold shared) and writebacks over a single valid/ready request channel. Each request carries the source cache index and the block index.

For each request the controller looks up the block's entry and works out which caches must act. It sends point-to-point invalidate or fetch pulses only to the caches whose presence bit is set. It then waits until every targeted cache has acknowledged. Only after that does it update the entry and return a response that names the requester and the resulting state. When dirty data has to reach memory, a writeback strobe accompanies the response.

Only one transaction is open at a time, so updates to any one block are applied in order.

Top module: `dir_ctrl`

## Requirements
- R1: After reset every entry is Uncached (state code 0) with an empty bitmap, req_ready is high, and rsp_valid, mem_wb, inv_vec and fetch_vec are all low.
- R2: A read (op code 0) to an Uncached or Shared block sends no message. It responds with state Shared (code 1) and adds the requester to the bitmap.
- R3: A read to a block that is Exclusive (code 2) at another cache sends a one-cycle fetch pulse only to that owner (bit i of fetch_vec addresses cache i). Once that pulse is acknowledged, the response gives Shared with mem_wb high. The bitmap then holds both the owner and the requester.
- R4: A write miss (op 1) or upgrade (op 2) sends one invalidate pulse on inv_vec to every other cache in the bitmap and never to the requester. With no other holder it sends nothing. The response gives Exclusive, and the bitmap then holds only the requester.
- R5: A write miss or upgrade to a block that is Exclusive at another cache invalidates that owner. It also pulses mem_wb with the block index in the response cycle.
- R6: The response is withheld until every targeted cache has raised its bit of ack_vec. The acknowledgements may arrive in any grouping and over any number of cycles.
- R7: req_ready drops in the cycle after a request is accepted and stays low until the response cycle has passed, so one transaction is open at a time.
- R8: A writeback (op 3) from the sole owner of an Exclusive block makes the entry Uncached with an empty bitmap, pulses mem_wb, and responds with state 0. A writeback from any other cache changes nothing, raises no mem_wb, and reports the current state.
- R9: A read or write from the cache that already owns an Exclusive block sends no message and leaves the entry Exclusive at that cache.
- R10: Without messages, rsp_valid is high for exactly the second cycle after acceptance. With messages, the pulse appears in that second cycle and the response follows in the cycle after the last acknowledgement. rsp_valid is always a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_op | input | 2 | 0 read, 1 write miss, 2 upgrade, 3 writeback |
| req_src | input | SRC_W | Requesting cache index |
| req_blk | input | BLK_W | Block index |
| inv_vec | output | N_CACHE | One-cycle invalidate pulse per target cache |
| fetch_vec | output | N_CACHE | One-cycle fetch pulse to the owner |
| msg_blk | output | BLK_W | Block the messages refer to |
| ack_vec | input | N_CACHE | Acknowledgement from each cache |
| rsp_valid | output | 1 | Response pulse |
| rsp_dst | output | SRC_W | Cache the response is for |
| rsp_blk | output | BLK_W | Block of the response |
| rsp_state | output | 2 | Resulting entry state (0/1/2) |
| mem_wb | output | 1 | Writeback strobe to memory |
| mem_wb_blk | output | BLK_W | Block being written back |

## Verification
Two events can fall in the same cycle: the final acknowledgement from one cache, and the acknowledgement from another. Several caches may also answer together while others are still outstanding. The bench provokes this by splitting each target set into random subsets, sometimes all at once and sometimes bit by bit, with idle gaps between them. A response that appears before the last bit, or that fails to appear the cycle after it, is judged against the bench's own record of the outstanding set. A second overlap is a new request held on the channel while messages are out. The check there is that req_ready stays low until the response has been given.

// File: rtl/dircoh_pkg.sv
package dircoh_pkg;
  typedef enum logic [1:0] {DS_UNC = 2'd0, DS_SHR = 2'd1, DS_EXC = 2'd2} dstate_e;
  typedef enum logic [1:0] {RQ_RD = 2'd0, RQ_WR = 2'd1, RQ_UPG = 2'd2, RQ_WB = 2'd3} rqop_e;
  typedef enum logic [1:0] {FS_IDLE = 2'd0, FS_LOOK = 2'd1, FS_WAIT = 2'd2, FS_RESP = 2'd3} fsm_e;
endpackage

// File: rtl/dir_store.sv
module dir_store
  import dircoh_pkg::*;
#(
  parameter int N_CACHE = 4,
  parameter int N_BLK   = 8,
  localparam int IW     = $clog2(N_BLK)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IW-1:0]      rd_idx,
  output dstate_e            rd_state,
  output logic [N_CACHE-1:0] rd_bits,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  dstate_e            wr_state,
  input  logic [N_CACHE-1:0] wr_bits
);
  logic [1:0]         st_q   [N_BLK];
  logic [N_CACHE-1:0] bits_q [N_BLK];

  for (genvar g = 0; g < N_BLK; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g]   <= DS_UNC;
        bits_q[g] <= '0;
      end else if (wr_en && wr_idx == IW'(g)) begin
        st_q[g]   <= wr_state;
        bits_q[g] <= wr_bits;
      end
    end
  end

  assign rd_state = dstate_e'(st_q[rd_idx]);
  assign rd_bits  = bits_q[rd_idx];

  // R4
  excl_single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_state == DS_EXC) |-> ($countones(wr_bits) == 1));
  // R8
  unc_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_state == DS_UNC) |-> (wr_bits == '0));
endmodule

// File: rtl/dir_decide.sv
module dir_decide
  import dircoh_pkg::*;
#(
  parameter int N_CACHE = 4,
  localparam int SW     = $clog2(N_CACHE)
) (
  input  rqop_e              op,
  input  logic [SW-1:0]      src,
  input  dstate_e            cur_st,
  input  logic [N_CACHE-1:0] cur_bits,
  output logic [N_CACHE-1:0] tgt_mask,
  output logic               tgt_fetch,
  output dstate_e            nx_st,
  output logic [N_CACHE-1:0] nx_bits,
  output logic               do_wb
);
  function automatic logic [N_CACHE-1:0] src_bit(input logic [SW-1:0] s);
    logic [N_CACHE-1:0] v;
    v = '0;
    v[s] = 1'b1;
    return v;
  endfunction

  function automatic logic [N_CACHE-1:0] others_of(input logic [N_CACHE-1:0] b,
                                                    input logic [SW-1:0] s);
    return b & ~src_bit(s);
  endfunction

  logic own_excl;
  assign own_excl = (cur_st == DS_EXC) && (cur_bits == src_bit(src));

  always_comb begin
    tgt_mask  = '0;
    tgt_fetch = 1'b0;
    nx_st     = cur_st;
    nx_bits   = cur_bits;
    do_wb     = 1'b0;
    unique case (op)
      RQ_RD: begin
        if (!own_excl) begin
          if (cur_st == DS_EXC) begin
            tgt_mask  = cur_bits;
            tgt_fetch = 1'b1;
            do_wb     = 1'b1;
          end
          nx_st   = DS_SHR;
          nx_bits = cur_bits | src_bit(src);
        end
      end
      RQ_WR, RQ_UPG: begin
        if (!own_excl) begin
          tgt_mask = others_of(cur_bits, src);
          do_wb    = (cur_st == DS_EXC);
          nx_st    = DS_EXC;
          nx_bits  = src_bit(src);
        end
      end
      RQ_WB: begin
        if (own_excl) begin
          nx_st   = DS_UNC;
          nx_bits = '0;
          do_wb   = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ack_tracker.sv
module ack_tracker #(
  parameter int N_CACHE = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [N_CACHE-1:0] load_mask,
  input  logic [N_CACHE-1:0] ack,
  output logic [N_CACHE-1:0] pending,
  output logic               drained
);
  always_ff @(posedge clk) begin
    if (!rst_n)    pending <= '0;
    else if (load) pending <= load_mask;
    else           pending <= pending & ~ack;
  end

  assign drained = ((pending & ~ack) == '0);

  // R6
  ack_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load) |-> ((ack & ~pending) == '0));
endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import dircoh_pkg::*;
#(
  parameter int N_CACHE = 4,
  parameter int N_BLK   = 8,
  localparam int SRC_W  = $clog2(N_CACHE),
  localparam int BLK_W  = $clog2(N_BLK)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_op,
  input  logic [SRC_W-1:0]   req_src,
  input  logic [BLK_W-1:0]   req_blk,
  output logic [N_CACHE-1:0] inv_vec,
  output logic [N_CACHE-1:0] fetch_vec,
  output logic [BLK_W-1:0]   msg_blk,
  input  logic [N_CACHE-1:0] ack_vec,
  output logic               rsp_valid,
  output logic [SRC_W-1:0]   rsp_dst,
  output logic [BLK_W-1:0]   rsp_blk,
  output logic [1:0]         rsp_state,
  output logic               mem_wb,
  output logic [BLK_W-1:0]   mem_wb_blk
);
  fsm_e               fs_q, fs_d;
  rqop_e              op_q;
  logic [SRC_W-1:0]   src_q;
  logic [BLK_W-1:0]   blk_q;
  dstate_e            nst_q;
  logic [N_CACHE-1:0] nbits_q;
  logic               wb_q;
  logic [N_CACHE-1:0] inv_q, fetch_q;

  dstate_e            cur_st, dec_st;
  logic [N_CACHE-1:0] cur_bits, dec_bits, dec_mask, pending;
  logic               dec_fetch, dec_wb, drained;

  // named internal events
  logic accept_evt, issue_evt, resp_evt;
  logic [N_CACHE-1:0] src_oh_q;

  assign accept_evt = req_valid && req_ready;
  assign issue_evt  = (fs_q == FS_LOOK) && (dec_mask != '0);
  assign resp_evt   = (fs_q == FS_RESP);
  assign src_oh_q   = N_CACHE'(1) << src_q;

  dir_store #(.N_CACHE(N_CACHE), .N_BLK(N_BLK)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(blk_q), .rd_state(cur_st), .rd_bits(cur_bits),
    .wr_en(resp_evt), .wr_idx(blk_q), .wr_state(nst_q), .wr_bits(nbits_q)
  );

  dir_decide #(.N_CACHE(N_CACHE)) u_decide (
    .op(op_q), .src(src_q), .cur_st(cur_st), .cur_bits(cur_bits),
    .tgt_mask(dec_mask), .tgt_fetch(dec_fetch),
    .nx_st(dec_st), .nx_bits(dec_bits), .do_wb(dec_wb)
  );

  ack_tracker #(.N_CACHE(N_CACHE)) u_acks (
    .clk(clk), .rst_n(rst_n),
    .load(issue_evt), .load_mask(dec_mask), .ack(ack_vec),
    .pending(pending), .drained(drained)
  );

  always_comb begin
    fs_d = fs_q;
    unique case (fs_q)
      FS_IDLE: if (accept_evt) fs_d = FS_LOOK;
      FS_LOOK: fs_d = issue_evt ? FS_WAIT : FS_RESP;
      FS_WAIT: if (drained) fs_d = FS_RESP;
      FS_RESP: fs_d = FS_IDLE;
      default: fs_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_q    <= FS_IDLE;
      op_q    <= RQ_RD;
      src_q   <= '0;
      blk_q   <= '0;
      nst_q   <= DS_UNC;
      nbits_q <= '0;
      wb_q    <= 1'b0;
      inv_q   <= '0;
      fetch_q <= '0;
    end else begin
      fs_q    <= fs_d;
      inv_q   <= '0;
      fetch_q <= '0;
      if (accept_evt) begin
        op_q  <= rqop_e'(req_op);
        src_q <= req_src;
        blk_q <= req_blk;
      end
      if (fs_q == FS_LOOK) begin
        nst_q   <= dec_st;
        nbits_q <= dec_bits;
        wb_q    <= dec_wb;
        if (dec_fetch) fetch_q <= dec_mask;
        else           inv_q   <= dec_mask;
      end
    end
  end

  assign req_ready  = (fs_q == FS_IDLE);
  assign inv_vec    = inv_q;
  assign fetch_vec  = fetch_q;
  assign msg_blk    = blk_q;
  assign rsp_valid  = resp_evt;
  assign rsp_dst    = src_q;
  assign rsp_blk    = blk_q;
  assign rsp_state  = nst_q;
  assign mem_wb     = resp_evt && wb_q;
  assign mem_wb_blk = blk_q;

  // R7
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !req_ready);
  // R3
  fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fetch_vec) <= 1);
  // R3
  msg_kind_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((inv_vec != '0) && (fetch_vec != '0)));
  // R4
  inv_not_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((inv_vec & src_oh_q) == '0));
  // R6
  resp_after_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (pending == '0));
  // R10
  rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R8
  wb_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wb |-> rsp_valid);
endmodule

// File: tb/tb_dir_ctrl.sv
module tb_dir_ctrl;
  localparam int NC = 4;
  localparam int NB = 8;
  localparam int SW = $clog2(NC);
  localparam int BW = $clog2(NB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = '0;
  logic [SW-1:0] req_src = '0;
  logic [BW-1:0] req_blk = '0;
  logic [NC-1:0] inv_vec, fetch_vec, ack_vec;
  logic [BW-1:0] msg_blk, rsp_blk, mem_wb_blk;
  logic rsp_valid, mem_wb;
  logic [SW-1:0] rsp_dst;
  logic [1:0] rsp_state;

  int checks = 0;
  int errors = 0;
  int mst[NB];
  int mbits[NB];

  always #10 clk = ~clk;

  dir_ctrl #(.N_CACHE(NC), .N_BLK(NB)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_src(req_src), .req_blk(req_blk),
    .inv_vec(inv_vec), .fetch_vec(fetch_vec), .msg_blk(msg_blk), .ack_vec(ack_vec),
    .rsp_valid(rsp_valid), .rsp_dst(rsp_dst), .rsp_blk(rsp_blk), .rsp_state(rsp_state),
    .mem_wb(mem_wb), .mem_wb_blk(mem_wb_blk)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bench-side restatement of the protocol
  task automatic predict(input int op, input int src, input int blk,
                         output int mask, output int fet, output int ns,
                         output int nb, output int wb);
    int oh, st, b;
    oh = 1 << src; st = mst[blk]; b = mbits[blk];
    mask = 0; fet = 0; ns = st; nb = b; wb = 0;
    if (op == 3) begin
      if (st == 2 && b == oh) begin ns = 0; nb = 0; wb = 1; end
    end else if (st == 2 && b == oh) begin
      // owner asks again: nothing changes
    end else if (op == 0) begin
      if (st == 2) begin mask = b; fet = 1; wb = 1; end
      ns = 1; nb = b | oh;
    end else begin
      mask = b & ~oh; wb = (st == 2) ? 1 : 0; ns = 2; nb = oh;
    end
  endtask

  task automatic txn(input int op, input int src, input int blk, input bit burst);
    int mask, fet, ns, nb, wb, remain, sub;
    predict(op, src, blk, mask, fet, ns, nb, wb);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_src = SW'(src); req_blk = BW'(blk);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 ready low after accept", int'(req_ready), 0);
    chk("R10 no early rsp", int'(rsp_valid), 0);
    @(negedge clk);
    if (mask != 0) begin
      chk("R4 inv targets", int'(inv_vec), fet ? 0 : mask);
      chk("R3 fetch target", int'(fetch_vec), fet ? mask : 0);
      chk("R3 msg block", int'(msg_blk), blk);
      // hold a competing request while messages are out
      req_valid = 1'b1; req_op = 2'd0; req_src = SW'(src ^ 1); req_blk = BW'(blk);
      remain = mask;
      while (remain != 0) begin
        sub = burst ? remain : (remain & int'($urandom_range(0, (1 << NC) - 1)));
        if (sub == 0) sub = remain & (-remain);
        ack_vec = NC'(sub);
        @(negedge clk);
        ack_vec = '0;
        remain = remain & ~sub;
        if (remain != 0) begin
          chk("R6 rsp held for acks", int'(rsp_valid), 0);
          chk("R7 stall while open", int'(req_ready), 0);
          if ($urandom_range(0, 2) == 0) @(negedge clk);
        end
      end
      req_valid = 1'b0;
    end else begin
      chk("R2 no messages", int'(inv_vec | fetch_vec), 0);
    end
    chk("R10 rsp pulse", int'(rsp_valid), 1);
    chk("R7 still busy in rsp", int'(req_ready), 0);
    chk("R2 rsp dst", int'(rsp_dst), src);
    chk("R2 rsp blk", int'(rsp_blk), blk);
    chk("R4 rsp state", int'(rsp_state), ns);
    chk("R5 wb strobe", int'(mem_wb), wb);
    if (wb != 0) chk("R8 wb blk", int'(mem_wb_blk), blk);
    mst[blk] = ns; mbits[blk] = nb;
    @(negedge clk);
    chk("R10 rsp one cycle", int'(rsp_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    ack_vec = '0;
    for (int i = 0; i < NB; i++) begin mst[i] = 0; mbits[i] = 0; end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", int'(req_ready), 1);
    chk("R1 rsp low", int'(rsp_valid), 0);
    chk("R1 msgs low", int'(inv_vec | fetch_vec), 0);
    chk("R1 wb low", int'(mem_wb), 0);
    // directed corners
    txn(0, 0, 1, 0);   // R2 read of Uncached
    txn(0, 1, 1, 0);   // R2 read of Shared
    txn(2, 0, 1, 0);   // R4 upgrade invalidates cache 1
    txn(0, 2, 1, 0);   // R3 fetch from owner 0
    txn(1, 3, 1, 1);   // R4 two invalidates acked together
    txn(0, 3, 1, 0);   // R9 owner reads
    txn(1, 3, 1, 0);   // R9 owner writes
    txn(3, 2, 1, 0);   // R8 non-owner writeback ignored
    txn(0, 0, 1, 0);   // R8 proves owner still held (fetch to 3)
    txn(1, 2, 1, 0);   // R4 invalidate 0 and 3, split acks
    txn(3, 2, 1, 0);   // R8 owner writeback
    txn(0, 1, 1, 0);   // R8 then Uncached: no messages
    txn(1, 0, 2, 0);   // R5 take exclusive
    txn(1, 1, 2, 0);   // R5 steal from owner: inv + wb
    for (int n = 0; n < 400; n++)
      txn(int'($urandom_range(0, 3)), int'($urandom_range(0, NC - 1)),
          int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule